// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two single-precision IEEE-754 operands under one of sixteen predicate codes. It returns a one-bit condition that a control register captures, and an invalid-operation flag. A caller raises `start_i` for one cycle and drives the predicate code and both operands in that cycle. One clock later the unit presents the new condition value with a one-cycle write strobe, and the invalid flag with it.

Every predicate is a mix of three terms. The unordered term is true when either operand is a NaN. The equal term is A = B and the less-than term is A < B; both are false whenever the operands are unordered. The upper half of the code space holds the signalling predicates. These have the same conditions as the quiet half, and in addition they raise invalid when a NaN is present.

Top module: `fcmp_pred_unit`

## Requirements
- R1: `cond_we_o` is high for exactly one cycle: the cycle after a cycle in which `start_i` was high. It is low at all other times, and also low during reset.
- R2: Code bit 3 selects signalling (1) or quiet (0). Bits 2..0 are an inclusion mask: bit 0 adds the unordered term, bit 1 adds the equal term, bit 2 adds the less-than term. The condition is the OR of the selected terms. With code bit 3 low, codes 0..7 are F, UN, EQ, UEQ, OLT, ULT, OLE, ULE. Codes 8..15 give the same conditions in signalling form.
- R3: An operand is a NaN when its 8-bit exponent field (bits 30..23) is all ones and its 23-bit fraction (bits 22..0) is nonzero. When either operand is a NaN, the equal and less-than terms are both false.
- R4: Ordered operands compare by numeric value, and this includes denormals and infinities. +0 and -0 compare equal, and neither is less than the other.
- R5: Codes 0 and 8 always write a condition value of 0.
- R6: For codes 8..15, `invalid_o` is high together with the strobe whenever either operand is a NaN, and this includes code 8. `invalid_o` is never high without `cond_we_o`.
- R7: For codes 0..7, `invalid_o` stays low whatever the operands are.
- R8: `cond_val_o` resets to 0. It changes only in a strobe cycle and otherwise holds the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-compare strobe |
| pred_i | input | 4 | Predicate code |
| opa_i | input | 32 | Operand A, single precision |
| opb_i | input | 32 | Operand B, single precision |
| cond_we_o | output | 1 | Condition-bit write strobe |
| cond_val_o | output | 1 | Condition-bit value |
| invalid_o | output | 1 | Invalid-operation flag, valid with the strobe |

## Verification
The bound checker tests properties on every cycle: the strobe timing, that invalid only ever appears with the strobe, that quiet codes never raise invalid, that signalling codes always raise it on a NaN, that F and SF always produce zero, that the held value stays stable, and that the relation terms are empty when the operands are unordered. Whether the equal and less-than terms give the right numeric ordering can only be shown by the bench. It sweeps every pair from a set of signed zeros, denormals, normals, infinities and both NaN kinds across all sixteen codes, and it computes each expected result from a signed ordering key of its own.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int FP_EXP_W  = 8;
  localparam int FP_MAN_W  = 23;
  localparam int PRED_W    = 4;

  // Predicate code fields; the bit positions are the code's meaning.
  typedef struct packed {
    logic sig;     // [3] signalling variant
    logic use_lt;  // [2] include A < B
    logic use_eq;  // [1] include A = B
    logic use_un;  // [0] include unordered
  } pred_fields_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = fcmp_pkg::FP_EXP_W,
  parameter int MAN_W = fcmp_pkg::FP_MAN_W,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [W-1:0]     op_i,
  output logic             is_nan_o,
  output logic             is_zero_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  function automatic logic f_nan(input logic [W-1:0] v);
    return (&v[W-2:MAN_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic f_zero(input logic [W-1:0] v);
    return ~|v[W-2:0];
  endfunction

  assign is_nan_o  = f_nan(op_i);
  assign is_zero_o = f_zero(op_i);
  assign sign_o    = op_i[W-1];
  assign mag_o     = op_i[W-2:0];
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate #(
  parameter int MAG_W = fcmp_pkg::FP_EXP_W + fcmp_pkg::FP_MAN_W
) (
  input  logic             nan_a_i,
  input  logic             nan_b_i,
  input  logic             zero_a_i,
  input  logic             zero_b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output logic             unord_o,
  output logic             eq_o,
  output logic             lt_o
);
  // Sign-magnitude less-than; signed zeros are one value.
  function automatic logic f_lt(input logic sa, input logic sb,
                                input logic [MAG_W-1:0] ma,
                                input logic [MAG_W-1:0] mb,
                                input logic za, input logic zb);
    if (za && zb)      return 1'b0;
    else if (sa != sb) return sa;
    else if (!sa)      return ma < mb;
    else               return ma > mb;
  endfunction

  function automatic logic f_eq(input logic sa, input logic sb,
                                input logic [MAG_W-1:0] ma,
                                input logic [MAG_W-1:0] mb,
                                input logic za, input logic zb);
    return (za && zb) || ((sa == sb) && (ma == mb));
  endfunction

  assign unord_o = nan_a_i | nan_b_i;
  assign eq_o = !unord_o &&
                f_eq(sign_a_i, sign_b_i, mag_a_i, mag_b_i, zero_a_i, zero_b_i);
  assign lt_o = !unord_o &&
                f_lt(sign_a_i, sign_b_i, mag_a_i, mag_b_i, zero_a_i, zero_b_i);
endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [PRED_W-1:0] pred_i,
  input  logic              unord_i,
  input  logic              eq_i,
  input  logic              lt_i,
  output logic              cond_o,
  output logic              invalid_o
);
  pred_fields_t fld;

  always_comb begin
    fld       = pred_fields_t'(pred_i);
    cond_o    = (fld.use_un & unord_i) | (fld.use_eq & eq_i) | (fld.use_lt & lt_i);
    invalid_o = fld.sig & unord_i;
  end
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic              cond_we_o,
  output logic              cond_val_o,
  output logic              invalid_o
);
  localparam int NOPS = 2;

  logic [W-1:0]     ops     [NOPS];
  logic             op_nan  [NOPS];
  logic             op_zero [NOPS];
  logic             op_sign [NOPS];
  logic [MAG_W-1:0] op_mag  [NOPS];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i     (ops[g]),
      .is_nan_o (op_nan[g]),
      .is_zero_o(op_zero[g]),
      .sign_o   (op_sign[g]),
      .mag_o    (op_mag[g])
    );
  end

  // Internal events, visible to the bound checker.
  logic unord, rel_eq, rel_lt, cond_nxt, inv_nxt;

  fcmp_relate #(.MAG_W(MAG_W)) u_rel (
    .nan_a_i (op_nan[0]),  .nan_b_i (op_nan[1]),
    .zero_a_i(op_zero[0]), .zero_b_i(op_zero[1]),
    .sign_a_i(op_sign[0]), .sign_b_i(op_sign[1]),
    .mag_a_i (op_mag[0]),  .mag_b_i (op_mag[1]),
    .unord_o (unord),
    .eq_o    (rel_eq),
    .lt_o    (rel_lt)
  );

  fcmp_decode u_dec (
    .pred_i   (pred_i),
    .unord_i  (unord),
    .eq_i     (rel_eq),
    .lt_i     (rel_lt),
    .cond_o   (cond_nxt),
    .invalid_o(inv_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_we_o  <= 1'b0;
      cond_val_o <= 1'b0;
      invalid_o  <= 1'b0;
    end else begin
      cond_we_o <= start_i;
      invalid_o <= start_i & inv_nxt;
      if (start_i) cond_val_o <= cond_nxt;
    end
  end
endmodule

// File: rtl/fcmp_pred_unit_chk.sv
module fcmp_pred_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [3:0] pred_i,
  input logic       cond_we_o,
  input logic       cond_val_o,
  input logic       invalid_o,
  input logic       unord,
  input logic       rel_eq,
  input logic       rel_lt
);
  assert_strobe_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cond_we_o == $past(start_i && rst_n));

  assert_unord_kills_rel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unord |-> !(rel_eq || rel_lt));

  assert_eq_lt_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_eq && rel_lt));

  assert_false_pred_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && rst_n && pred_i[2:0] == 3'd0) |-> !cond_val_o);

  assert_sig_nan_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && rst_n && pred_i[3] && unord) |-> invalid_o);

  assert_invalid_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> cond_we_o);

  assert_quiet_no_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && !pred_i[3]) |-> !invalid_o);

  assert_hold_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_we_o |-> $stable(cond_val_o));
endmodule

bind fcmp_pred_unit fcmp_pred_unit_chk u_chk (.*);

// File: tb/fcmp_pred_unit_tb.sv
module fcmp_pred_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  pred_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        cond_we_o, cond_val_o, invalid_o;

  int n_tests = 0;
  int n_fail  = 0;

  // +0 -0 +1 -1 +2 -2 +den -den +inf -inf qNaN sNaN(neg)
  localparam logic [31:0] VALS [NV] = '{
    32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
    32'h40000000, 32'hC0000000, 32'h00000001, 32'h80000001,
    32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'hFF800001 };

  fcmp_pred_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit tb_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  // Signed ordering key: bit pattern magnitude, negated for negative sign.
  function automatic longint tb_key(input logic [31:0] v);
    longint m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction

  function automatic bit tb_cond(input logic [3:0] code, input logic [31:0] a,
                                 input logic [31:0] b);
    bit un = tb_nan(a) || tb_nan(b);
    bit eq = !un && (tb_key(a) == tb_key(b));
    bit lt = !un && (tb_key(a) <  tb_key(b));
    case (code[2:0])
      3'd0: return 1'b0;        // F / SF
      3'd1: return un;          // UN / NGLE
      3'd2: return eq;          // EQ / SEQ
      3'd3: return un || eq;    // UEQ / NGL
      3'd4: return lt;          // OLT / LT
      3'd5: return un || lt;    // ULT / NGE
      3'd6: return lt || eq;    // OLE / LE
      default: return un || lt || eq; // ULE / NGT
    endcase
  endfunction

  task automatic run_cmp(input logic [3:0] code, input logic [31:0] a,
                         input logic [31:0] b, output bit c, output bit inv);
    @(negedge clk);
    start_i = 1'b1; pred_i = code; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk(cond_we_o == 1'b1, "R1 strobe", 32'(cond_we_o), 32'd1);
    c = cond_val_o; inv = invalid_o;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit c, inv, held;
    repeat (3) @(negedge clk);
    chk({cond_we_o, cond_val_o, invalid_o} == 3'b000, "R8 reset state",
        32'({cond_we_o, cond_val_o, invalid_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cond_we_o == 1'b0, "R1 no strobe idle", 32'(cond_we_o), 32'd0);

    // Directed corners.
    run_cmp(4'd2, 32'h00000000, 32'h80000000, c, inv);
    chk(c == 1'b1, "R4 +0 EQ -0", 32'(c), 32'd1);
    run_cmp(4'd4, 32'h80000000, 32'h00000000, c, inv);
    chk(c == 1'b0, "R4 -0 OLT +0", 32'(c), 32'd0);
    run_cmp(4'd6, 32'h7FC00000, 32'h7FC00000, c, inv);
    chk(c == 1'b0, "R3 NaN OLE NaN", 32'(c), 32'd0);
    run_cmp(4'd8, 32'h3F800000, 32'h7FC00000, c, inv);
    chk(c == 1'b0 && inv == 1'b1, "R5 R6 SF with NaN",
        32'({c, inv}), 32'b01);
    // Strobe lasts one cycle; value holds while idle with new inputs.
    held = cond_val_o;
    opa_i = 32'hFF800000; opb_i = 32'h7F800000; pred_i = 4'd7;
    @(negedge clk);
    chk(cond_we_o == 1'b0 && invalid_o == 1'b0, "R1 R6 single-cycle pulse",
        32'({cond_we_o, invalid_o}), 32'd0);
    chk(cond_val_o == held, "R8 hold without start", 32'(cond_val_o), 32'(held));

    // Sweep: all operand pairs under all codes.
    for (int ia = 0; ia < NV; ia++) begin
      for (int ib = 0; ib < NV; ib++) begin
        for (int code = 0; code < 16; code++) begin
          bit ec, einv, un;
          un   = tb_nan(VALS[ia]) || tb_nan(VALS[ib]);
          ec   = tb_cond(4'(code), VALS[ia], VALS[ib]);
          einv = (code >= 8) && un;
          run_cmp(4'(code), VALS[ia], VALS[ib], c, inv);
          if ((code % 8) == 0)
            chk(c == 1'b0, "R5 false predicate", 32'(c), 32'd0);
          else
            chk(c == ec, "R2 R3 R4 condition", {ia[7:0], ib[7:0], 8'(code), 7'd0, c},
                {ia[7:0], ib[7:0], 8'(code), 7'd0, ec});
          if (code >= 8)
            chk(inv == einv, "R6 signalling invalid", 32'(inv), 32'(einv));
          else
            chk(inv == 1'b0, "R7 quiet no invalid", 32'(inv), 32'd0);
        end
      end
    end

    @(negedge clk);
    chk(cond_we_o == 1'b0, "R1 strobe ends", 32'(cond_we_o), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule